// File: doc/BRIEF.md
# Asynchronous Static RAM Access Controller

This block sits between a clocked host and an asynchronous static RAM. The host makes one single-word request at a time over a valid/ready handshake, with a write flag, an address and write data. The controller then drives the memory's address, active-low chip enable, output enable and write enable with timing that meets the memory's minimums, and for a read it returns the captured word together with a one-cycle done pulse.

Every timing minimum is a parameter in nanoseconds. Each one becomes a cycle count by ceiling division by the clock period, and is never less than one cycle. Writes are ended by write enable while output enable stays low. Because the memory may still be driving the bus just after write enable falls, the controller holds its own data drivers off for a release delay before it drives. After a read it also waits for the memory to let go of the bus before it accepts the next request. No request is accepted until a power-up interval has passed since reset.

Top module: `sram_ctl`

## Requirements
- R1: After reset is released, `req_ready` stays low for exactly PWR cycles, where PWR = ceil(T_PWR_NS / CLK_NS). The controller accepts nothing and drives no strobe low during that time. Whenever `req_ready` is high, all three strobes are high.
- R2: While reset is held and in the first cycle after it, all strobes are high and `sram_dq_oe`, `rsp_done` and `req_ready` are low.
- R3: A request is accepted on a clock edge where `req_valid` and `req_ready` are both high, and `req_ready` is low in the cycle after that edge. `sram_addr` changes only while chip enable is high.
- R4: For a read (`req_write` = 0), chip enable and output enable are low with write enable high for RD cycles, where RD is the largest of the rounded read cycle, address access, chip-enable access and output-enable access times. `rsp_done` is high for exactly one cycle, 1+RD cycles after the accepting edge, with the captured word on `rsp_rdata`.
- R5: For a write (`req_write` = 1), chip enable, output enable and write enable go low on the same edge and stay low for WR cycles. WR is the largest of the rounded write-enable pulse, chip-enable-to-end, address-to-end and write cycle times, and of HZ+SD (rounded write-enable release delay plus rounded data setup). `rsp_done` pulses 1+WR cycles after the accepting edge. Write enable is never low while chip enable is high.
- R6: `sram_dq_oe` is high only while write enable is low, and only in the last WR-HZ cycles of the strobe. It drops on the edge that raises write enable. While it is high, `sram_dq_out` carries the accepted write data.
- R7: After a read, `req_ready` returns TA cycles after the done cycle, where TA is the larger of the rounded output-enable and chip-enable release times. After a write, it returns one cycle after the done cycle. `sram_dq_oe` stays low in the cycle after output enable rises.
- R8: A read returns the data of the most recent write to that address.
- R9: If `req_valid` is raised and then dropped while `req_ready` is low, nothing is accepted. No strobe falls and no done pulse follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Host request valid |
| req_ready | output | 1 | Controller can accept a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | DATA_W | Write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DATA_W | Read data, valid with rsp_done |
| sram_addr | output | ADDR_W | Memory address |
| sram_ce_n | output | 1 | Chip enable, active low |
| sram_oe_n | output | 1 | Output enable, active low |
| sram_we_n | output | 1 | Write enable, active low |
| sram_dq_out | output | DATA_W | Data toward the memory |
| sram_dq_oe | output | 1 | Drive enable for sram_dq_out |
| sram_dq_in | input | DATA_W | Data from the memory |

## Verification
The checker watches every cycle for the strobe relationships that must always hold. These are: the address stays stable while chip enable is low, write enable is never low without chip enable, the data drivers are off on the edges where write enable falls and rises and just after output enable rises, done is a single-cycle pulse that coincides with the end of a strobe, and ready is only high when all strobes are idle. The bench covers what needs a whole transaction or a memory model: the exact power-up delay, the strobe and drive lengths, the done and ready latencies, and read data matching earlier writes. It also drives a memory model that reports bus contention, and it checks that a request withdrawn during power-up is ignored.

// File: rtl/sram_ctl_pkg.sv
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_STROBE,
    ST_RECOVER,
    ST_TURN
  } st_e;

  // nanoseconds to clock cycles, rounded up, at least one
  function automatic int unsigned ns2cyc(input int unsigned ns, input int unsigned clk_ns);
    int unsigned c;
    c = (ns + clk_ns - 1) / clk_ns;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_ctl_pwrup.sv
module sram_ctl_pwrup #(
  parameter int unsigned CYCLES = 5000
) (
  input  logic clk,
  input  logic rst,
  output logic ok
);
  localparam int unsigned W = $clog2(CYCLES + 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= W'(CYCLES - 1);
      ok  <= 1'b0;
    end else if (!ok) begin
      if (cnt == '0) ok <= 1'b1;
      else           cnt <= cnt - 1'b1;
    end
  end
endmodule

// File: rtl/sram_ctl_seq.sv
module sram_ctl_seq
  import sram_ctl_pkg::*;
#(
  parameter int unsigned RD_STB = 1,
  parameter int unsigned WR_STB = 2,
  parameter int unsigned HZ_WE  = 1,
  parameter int unsigned TA     = 1,
  parameter int unsigned REC    = 1
) (
  input  logic clk,
  input  logic rst,
  input  logic pwr_ok,
  input  logic req_valid,
  input  logic req_write,
  output logic ready,
  output logic accept,
  output logic capture,
  output logic ce_n,
  output logic oe_n,
  output logic we_n,
  output logic dq_oe,
  output logic done
);
  localparam int unsigned CMAX = max2(max2(RD_STB, WR_STB), max2(TA, REC));
  localparam int unsigned CW   = $clog2(CMAX + 1);
  localparam logic [CW-1:0] DRIVE_AT = CW'(WR_STB - HZ_WE);

  st_e           st;
  logic [CW-1:0] cnt;
  logic          is_wr;

  assign ready   = (st == ST_IDLE) && pwr_ok;
  assign accept  = ready && req_valid;
  assign capture = (st == ST_STROBE) && (cnt == '0) && !is_wr;

  always_ff @(posedge clk) begin
    if (rst) begin
      st    <= ST_IDLE;
      cnt   <= '0;
      is_wr <= 1'b0;
      ce_n  <= 1'b1;
      oe_n  <= 1'b1;
      we_n  <= 1'b1;
      dq_oe <= 1'b0;
      done  <= 1'b0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (accept) begin
            st    <= ST_SETUP;
            is_wr <= req_write;
          end
        end
        ST_SETUP: begin
          st   <= ST_STROBE;
          ce_n <= 1'b0;
          oe_n <= 1'b0;
          we_n <= !is_wr;
          cnt  <= is_wr ? CW'(WR_STB - 1) : CW'(RD_STB - 1);
        end
        ST_STROBE: begin
          if (cnt == '0) begin
            ce_n  <= 1'b1;
            oe_n  <= 1'b1;
            we_n  <= 1'b1;
            dq_oe <= 1'b0;
            done  <= 1'b1;
            if (is_wr) begin
              st  <= ST_RECOVER;
              cnt <= CW'(REC - 1);
            end else begin
              st  <= ST_TURN;
              cnt <= CW'(TA - 1);
            end
          end else begin
            cnt <= cnt - 1'b1;
            if (is_wr && cnt == DRIVE_AT) dq_oe <= 1'b1;
          end
        end
        ST_RECOVER, ST_TURN: begin
          if (cnt == '0) st <= ST_IDLE;
          else           cnt <= cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/sram_ctl_dpath.sv
module sram_ctl_dpath #(
  parameter int unsigned ADDR_W = 10,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic              capture,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [DATA_W-1:0] in_wdata,
  input  logic [DATA_W-1:0] mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wd,
  output logic [DATA_W-1:0] rdata
);
  always_ff @(posedge clk) begin
    if (rst) begin
      mem_addr <= '0;
      mem_wd   <= '0;
      rdata    <= '0;
    end else begin
      if (accept) begin
        mem_addr <= in_addr;
        mem_wd   <= in_wdata;
      end
      if (capture) rdata <= mem_rd;
    end
  end
endmodule

// File: rtl/sram_ctl.sv
module sram_ctl
  import sram_ctl_pkg::*;
#(
  parameter int unsigned ADDR_W    = 10,
  parameter int unsigned DATA_W    = 16,
  parameter int unsigned CLK_NS    = 20,
  parameter int unsigned T_PWR_NS  = 100000,
  parameter int unsigned T_RC_NS   = 10,
  parameter int unsigned T_AA_NS   = 10,
  parameter int unsigned T_ACE_NS  = 10,
  parameter int unsigned T_DOE_NS  = 5,
  parameter int unsigned T_HZOE_NS = 5,
  parameter int unsigned T_HZCE_NS = 5,
  parameter int unsigned T_WC_NS   = 10,
  parameter int unsigned T_PWE_NS  = 7,
  parameter int unsigned T_SCE_NS  = 8,
  parameter int unsigned T_AW_NS   = 8,
  parameter int unsigned T_SD_NS   = 5,
  parameter int unsigned T_HZWE_NS = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] sram_addr,
  output logic              sram_ce_n,
  output logic              sram_oe_n,
  output logic              sram_we_n,
  output logic [DATA_W-1:0] sram_dq_out,
  output logic              sram_dq_oe,
  input  logic [DATA_W-1:0] sram_dq_in
);
  localparam int unsigned C_PWR = ns2cyc(T_PWR_NS, CLK_NS);
  localparam int unsigned C_RD  = max2(max2(ns2cyc(T_RC_NS, CLK_NS), ns2cyc(T_AA_NS, CLK_NS)),
                                       max2(ns2cyc(T_ACE_NS, CLK_NS), ns2cyc(T_DOE_NS, CLK_NS)));
  localparam int unsigned C_HZ  = ns2cyc(T_HZWE_NS, CLK_NS);
  localparam int unsigned C_WR  = max2(max2(max2(ns2cyc(T_PWE_NS, CLK_NS), ns2cyc(T_SCE_NS, CLK_NS)),
                                            max2(ns2cyc(T_AW_NS, CLK_NS), ns2cyc(T_WC_NS, CLK_NS))),
                                       C_HZ + ns2cyc(T_SD_NS, CLK_NS));
  localparam int unsigned C_TA  = max2(ns2cyc(T_HZOE_NS, CLK_NS), ns2cyc(T_HZCE_NS, CLK_NS));

  logic pwr_ok;
  logic accept;
  logic capture;

  sram_ctl_pwrup #(.CYCLES(C_PWR)) pwrup_i (
    .clk (clk),
    .rst (rst),
    .ok  (pwr_ok)
  );

  sram_ctl_seq #(
    .RD_STB (C_RD),
    .WR_STB (C_WR),
    .HZ_WE  (C_HZ),
    .TA     (C_TA),
    .REC    (1)
  ) seq_i (
    .clk       (clk),
    .rst       (rst),
    .pwr_ok    (pwr_ok),
    .req_valid (req_valid),
    .req_write (req_write),
    .ready     (req_ready),
    .accept    (accept),
    .capture   (capture),
    .ce_n      (sram_ce_n),
    .oe_n      (sram_oe_n),
    .we_n      (sram_we_n),
    .dq_oe     (sram_dq_oe),
    .done      (rsp_done)
  );

  sram_ctl_dpath #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) dpath_i (
    .clk      (clk),
    .rst      (rst),
    .accept   (accept),
    .capture  (capture),
    .in_addr  (req_addr),
    .in_wdata (req_wdata),
    .mem_rd   (sram_dq_in),
    .mem_addr (sram_addr),
    .mem_wd   (sram_dq_out),
    .rdata    (rsp_rdata)
  );
endmodule

// File: rtl/sram_ctl_chk.sv
module sram_ctl_chk #(
  parameter int unsigned ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              req_ready,
  input logic              rsp_done,
  input logic [ADDR_W-1:0] sram_addr,
  input logic              sram_ce_n,
  input logic              sram_oe_n,
  input logic              sram_we_n,
  input logic              sram_dq_oe
);
  // R1
  ready_idle_chk: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (sram_ce_n && sram_oe_n && sram_we_n));

  // R3
  addr_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!sram_ce_n && $past(!sram_ce_n)) |-> $stable(sram_addr));

  // R4
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

  // R4
  done_at_end_chk: assert property (@(posedge clk) disable iff (rst)
    rsp_done |-> $rose(sram_ce_n));

  // R5
  we_needs_ce_chk: assert property (@(posedge clk) disable iff (rst)
    !sram_we_n |-> !sram_ce_n);

  // R6
  dq_in_strobe_chk: assert property (@(posedge clk) disable iff (rst)
    sram_dq_oe |-> (!sram_we_n && !sram_ce_n));

  // R6
  dq_late_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(sram_we_n) |-> !sram_dq_oe);

  // R6
  dq_release_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_we_n) |-> !sram_dq_oe);

  // R7
  turn_gap_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(sram_oe_n) |=> !sram_dq_oe);
endmodule

bind sram_ctl sram_ctl_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .req_ready  (req_ready),
  .rsp_done   (rsp_done),
  .sram_addr  (sram_addr),
  .sram_ce_n  (sram_ce_n),
  .sram_oe_n  (sram_oe_n),
  .sram_we_n  (sram_we_n),
  .sram_dq_oe (sram_dq_oe)
);

// File: tb/sram_ctl_tb_top.sv
module sram_ctl_tb_top;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int CLK = 20;

  function automatic int cyc(input int ns);
    int c;
    c = (ns + CLK - 1) / CLK;
    return (c < 1) ? 1 : c;
  endfunction
  function automatic int mx(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

  localparam int E_PWR = cyc(100000);
  localparam int E_RD  = mx(mx(cyc(10), cyc(10)), mx(cyc(10), cyc(5)));
  localparam int E_HZ  = cyc(5);
  localparam int E_WR  = mx(mx(mx(cyc(7), cyc(8)), mx(cyc(8), cyc(10))), E_HZ + cyc(5));
  localparam int E_TA  = mx(cyc(5), cyc(5));

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0;
  logic          req_ready;
  logic          req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [DW-1:0] req_wdata = '0;
  logic          rsp_done;
  logic [DW-1:0] rsp_rdata;
  logic [AW-1:0] sram_addr;
  logic          sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe;
  logic [DW-1:0] sram_dq_out;
  logic [DW-1:0] sram_dq_in;

  int checks = 0;
  int fails  = 0;
  int mon_fails = 0;
  bit pwr_phase = 1'b1;
  int early_strobes = 0;

  logic [DW-1:0] mem    [1<<AW];
  logic [DW-1:0] shadow [1<<AW];
  logic [DW-1:0] pend;
  bit            pend_ok;
  logic          we_prev;

  always #(CLK/2) clk = ~clk;

  sram_ctl dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_rdata(rsp_rdata), .sram_addr(sram_addr),
    .sram_ce_n(sram_ce_n), .sram_oe_n(sram_oe_n), .sram_we_n(sram_we_n),
    .sram_dq_out(sram_dq_out), .sram_dq_oe(sram_dq_oe), .sram_dq_in(sram_dq_in)
  );

  function automatic logic [DW-1:0] initv(input int a);
    return DW'(a * 16'h0101) ^ 16'h5A5A;
  endfunction

  // memory model drives the bus during a read strobe
  assign sram_dq_in = (!sram_ce_n && !sram_oe_n && sram_we_n) ? mem[sram_addr] : 16'h0000;

  initial begin
    for (int i = 0; i < (1<<AW); i++) begin
      mem[i] = initv(i);
      shadow[i] = initv(i);
    end
    pend = '0;
    pend_ok = 1'b0;
    we_prev = 1'b1;
  end

  // memory model: write commit and contention, sampled mid-cycle
  always @(negedge clk) begin
    if (!rst) begin
      if (pwr_phase && (!sram_ce_n || !sram_oe_n || !sram_we_n)) early_strobes++;
      if (sram_dq_oe && !sram_ce_n && !sram_oe_n && sram_we_n) begin
        mon_fails++;
        $display("FAIL R6: bus contention, controller drives during read strobe act=1 exp=0");
      end
      if (!sram_ce_n && !sram_we_n) begin
        if (sram_dq_oe) begin
          pend = sram_dq_out;
          pend_ok = 1'b1;
        end
      end
      if (!we_prev && sram_we_n) begin
        if (!pend_ok) begin
          mon_fails++;
          $display("FAIL R6: write ended without data driven act=0 exp=1");
        end
        mem[sram_addr] = pend;
        pend_ok = 1'b0;
      end
      we_prev = sram_we_n;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic do_op(input bit wr, input logic [AW-1:0] a, input logic [DW-1:0] d);
    int lat, back, ce_lo, we_lo, dq_hi, dq_first;
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    chk(!req_ready, "R3 ready low after accept", req_ready, 0);
    lat = 0; ce_lo = 0; we_lo = 0; dq_hi = 0; dq_first = -1;
    while (!rsp_done && lat < 50) begin
      @(posedge clk); @(negedge clk);
      lat++;
      if (!sram_ce_n) ce_lo++;
      if (!sram_we_n) we_lo++;
      if (sram_dq_oe) begin
        dq_hi++;
        if (dq_first < 0) dq_first = we_lo - 1;
        if (sram_dq_out !== d) chk(0, "R6 drive data", sram_dq_out, d);
      end
    end
    if (wr) begin
      chk(lat == 1 + E_WR, "R5 write done latency", lat, 1 + E_WR);
      chk(ce_lo == E_WR && we_lo == E_WR, "R5 write strobe length", we_lo, E_WR);
      chk(dq_hi == E_WR - E_HZ && dq_first == E_HZ, "R6 drive window", dq_hi, E_WR - E_HZ);
      shadow[a] = d;
    end else begin
      chk(lat == 1 + E_RD, "R4 read done latency", lat, 1 + E_RD);
      chk(ce_lo == E_RD && we_lo == 0 && dq_hi == 0, "R4 read strobe shape", ce_lo, E_RD);
      chk(rsp_rdata === shadow[a], "R8 read data", rsp_rdata, shadow[a]);
    end
    back = 0;
    @(posedge clk); @(negedge clk);
    chk(!rsp_done, "R4 done one cycle", rsp_done, 0);
    back = 1;
    while (!req_ready && back < 50) begin
      @(posedge clk); @(negedge clk);
      back++;
    end
    chk(back == (wr ? 1 : E_TA), "R7 ready return", back, wr ? 1 : E_TA);
  endtask

  initial begin
    #(CLK * 200000);
    fails++;
    $display("FAIL watchdog: act=timeout exp=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails + mon_fails);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5EED_0042));
    repeat (3) @(negedge clk);
    // R2 reset state
    chk(sram_ce_n && sram_oe_n && sram_we_n && !sram_dq_oe && !rsp_done && !req_ready,
        "R2 reset state", {sram_ce_n, sram_oe_n, sram_we_n, sram_dq_oe, rsp_done, req_ready}, 6'b111000);
    rst = 1'b0;
    n = 0;
    // R9: valid raised then dropped during power-up
    while (!req_ready && n < E_PWR + 10) begin
      if (n == 20) begin req_valid = 1'b1; req_write = 1'b1; end
      @(posedge clk);
      @(negedge clk);
      n++;
      if (n == 120) req_valid = 1'b0;
      if (n == 1) chk(sram_ce_n && !sram_dq_oe && !req_ready, "R2 first cycle", sram_ce_n, 1);
    end
    pwr_phase = 1'b0;
    chk(n == E_PWR, "R1 power-up delay", n, E_PWR);
    chk(early_strobes == 0, "R1 R9 no strobe before ready", early_strobes, 0);
    for (int i = 0; i < 6; i++) begin
      @(posedge clk); @(negedge clk);
      if (!sram_ce_n || rsp_done) chk(0, "R9 withdrawn request ignored", rsp_done, 0);
    end
    chk(req_ready && sram_ce_n, "R9 idle after withdrawn request", req_ready, 1);

    // directed corners
    do_op(1'b0, 10'd3, '0);
    do_op(1'b1, 10'd3, 16'hFFFF);
    do_op(1'b0, 10'd3, '0);
    do_op(1'b1, 10'h3FF, 16'h0000);
    do_op(1'b0, 10'h3FF, '0);
    do_op(1'b1, 10'd0, 16'hA5C3);
    do_op(1'b1, 10'd0, 16'h1234);
    do_op(1'b0, 10'd0, '0);

    // random mix on a small address window
    for (int k = 0; k < 300; k++) begin
      do_op(1'($urandom), AW'($urandom % 16), DW'($urandom));
    end

    chk(mon_fails == 0, "R6 memory model clean", mon_fails, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule